// File: doc/BRIEF.md
# Image Resize Coefficient Calculator

This block turns the input and output sizes of one image-resize job into the scaler's control word. For each dimension it checks that the sizes are legal and picks a power-of-two pre-decimation code that halves the input up to twice. It then divides to get a fixed-point step ratio with 13 fractional bits and clamps that ratio into a 14-bit field. The vertical and horizontal results are packed into one 32-bit word.

A caller drives the four sizes and pulses `start`. The block works through the vertical dimension and then the horizontal one, using a single shared restoring divider, and pulses `done` once. At that point the packed word, an error flag with its reason code and a saturation warning are all valid. These outputs hold until the next accepted start.

Top module: `rsz_coef_calc`

## Requirements
- R1: An input size above 4096 in a dimension aborts the job with `err`=1, `err_code`=1 and `rsc_word`=0.
- R2: An output size above 1024 in a dimension aborts the job with `err_code`=2.
- R3: An output size of 0 or 1, or an input size of 0, aborts the job with `err_code`=4. Within one dimension the checks take priority in the order code 1, code 2, code 4, code 3.
- R4: A shrink beyond 4:1 aborts the job with `err_code`=3. This is the case where the input size exceeds four times the output size.
- R5: The decimation code starts at 0 on the full input size. The size is halved (truncating) and the code incremented while the size is above 1024 or at least twice the output size, for as long as the code is below 2.
- R6: The coefficient is floor(8192 × (reduced size − 1) / (output size − 1)).
- R7: A coefficient of 16384 or more is replaced by 16383 (all ones), and `ovf_warn` is 1 at `done`. The job still completes with `err`=0. `ovf_warn` is 1 if either dimension saturated.
- R8: `rsc_word` holds the vertical code in bits 31:30, the vertical coefficient in bits 29:16, the horizontal code in bits 15:14 and the horizontal coefficient in bits 13:0.
- R9: `done` is high for exactly one cycle per job. `busy` is high from the cycle after the start until just before `done`. The result outputs keep their values after `done` until the next job finishes.
- R10: A `start` pulse while `busy` is high is ignored, and the running job's result is unaffected.
- R11: After reset, `busy`, `done`, `err`, `err_code`, `ovf_warn` and `rsc_word` are all 0.
- R12: The vertical dimension is checked first. If both dimensions are illegal, the vertical dimension's error code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only while idle |
| in_w | input | 16 | Input width in pixels |
| in_h | input | 16 | Input height in lines |
| out_w | input | 16 | Output width in pixels |
| out_h | input | 16 | Output height in lines |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| rsc_word | output | 32 | Packed decimation codes and coefficients |
| err | output | 1 | Job rejected |
| err_code | output | 3 | Reason: 0 none, 1 input too large, 2 output too large, 3 ratio too large, 4 illegal size |
| ovf_warn | output | 1 | A coefficient was saturated |

## Verification
Each dimension is swept over a grid of input and output sizes while the other dimension is held at a legal pair. The grid straddles 0, 1, 2, the 1024 and 4096 limits, and the exact 4:1 edge. This separates each error reason from the others, separates the three decimation codes, and separates saturated from unsaturated coefficients such as 3→2. Jobs where both dimensions are illegal show which dimension's code wins. A pseudo-random batch of legal and illegal sizes covers the truncating division away from the edges. A second start fired in the middle of a job shows that the running result is kept.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

   typedef enum logic [2:0] {
      RSZ_OK       = 3'd0,
      RSZ_IN_BIG   = 3'd1,
      RSZ_OUT_BIG  = 3'd2,
      RSZ_RATIO    = 3'd3,
      RSZ_SIZE_ILL = 3'd4
   } rsz_err_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_DIV,
      ST_FINISH
   } rsz_state_e;

endpackage

// File: rtl/rsz_prescale.sv
module rsz_prescale
   import rsz_pkg::*;
#(
   parameter int SZ_W      = 16,
   parameter int IN_LIMIT  = 4096,
   parameter int OUT_LIMIT = 1024,
   parameter int MAX_DS    = 2,
   parameter int DS_W      = 2,
   parameter int RED_W     = 13
) (
   input  logic [SZ_W-1:0]  in_sz,
   input  logic [SZ_W-1:0]  out_sz,
   output rsz_err_e         err,
   output logic [DS_W-1:0]  ds,
   output logic [RED_W-1:0] reduced
);

   localparam int SC_W = SZ_W + MAX_DS;
   localparam logic [SZ_W-1:0] IN_LIM_V  = SZ_W'(IN_LIMIT);
   localparam logic [SZ_W-1:0] OUT_LIM_V = SZ_W'(OUT_LIMIT);
   localparam logic [SZ_W-1:0] TWO_V     = SZ_W'(2);

   logic [SC_W-1:0] out_scaled;
   logic [SZ_W-1:0] sz;
   logic [DS_W-1:0] code;

   always_comb begin
      out_scaled = SC_W'(out_sz) << MAX_DS;
      if (in_sz > IN_LIM_V)
         err = RSZ_IN_BIG;
      else if (out_sz > OUT_LIM_V)
         err = RSZ_OUT_BIG;
      else if ((out_sz < TWO_V) || (in_sz == '0))
         err = RSZ_SIZE_ILL;
      else if (out_scaled < SC_W'(in_sz))
         err = RSZ_RATIO;
      else
         err = RSZ_OK;
   end

   // Unrolled halving: once the condition fails it stays false, so a
   // fixed MAX_DS steps reproduce the bounded loop.
   always_comb begin
      sz   = in_sz;
      code = '0;
      for (int k = 0; k < MAX_DS; k++) begin
         if ((sz > OUT_LIM_V) || ({1'b0, sz} >= {out_sz, 1'b0})) begin
            sz   = sz >> 1;
            code = code + 1'b1;
         end
      end
      ds      = code;
      reduced = sz[RED_W-1:0];
   end

endmodule

// File: rtl/rsz_div.sv
module rsz_div #(
   parameter int DVD_W = 26,
   parameter int DVS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             fin,
   output logic [DVD_W-1:0] quotient
);

   localparam int CNT_W = $clog2(DVD_W + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DVD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [DVS_W-1:0] rem_q;
   logic [DVS_W-1:0] dvs_q;
   logic [DVD_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [DVS_W:0]   trial;
   logic             fits;

   assign trial    = {rem_q, quo_q[DVD_W-1]};
   assign fits     = trial >= {1'b0, dvs_q};
   assign quotient = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvs_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem_q <= '0;
            dvs_q <= divisor;
            quo_q <= dividend;
            cnt_q <= CNT_LOAD;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (fits)
               rem_q <= DVS_W'(trial - {1'b0, dvs_q});
            else
               rem_q <= trial[DVS_W-1:0];
            quo_q <= {quo_q[DVD_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_LAST) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc
   import rsz_pkg::*;
#(
   parameter int SZ_W      = 16,
   parameter int IN_LIMIT  = 4096,
   parameter int OUT_LIMIT = 1024,
   parameter int MAX_DS    = 2,
   parameter int FRAC_BITS = 13,
   parameter int COEF_W    = 14
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [15:0] in_w,
   input  logic [15:0] in_h,
   input  logic [15:0] out_w,
   input  logic [15:0] out_h,
   output logic        busy,
   output logic        done,
   output logic [31:0] rsc_word,
   output logic        err,
   output logic [2:0]  err_code,
   output logic        ovf_warn
);

   localparam int DS_W   = $clog2(MAX_DS + 1);
   localparam int RED_W  = $clog2(IN_LIMIT + 1);
   localparam int DVS_W  = $clog2(OUT_LIMIT + 1);
   localparam int DVD_W  = RED_W + FRAC_BITS;
   localparam int HALF_W = DS_W + COEF_W;
   localparam int WORD_W = 2 * HALF_W;
   localparam logic [DVD_W-1:0] SAT_LIM = DVD_W'(2 ** COEF_W);

   if (SZ_W != 16) begin : g_bad_sz
      $error("SZ_W must match the 16-bit size ports");
   end
   if (SZ_W <= RED_W) begin : g_bad_lim
      $error("SZ_W too narrow to represent an oversize input");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("packed word must be 32 bits");
   end
   if (DVD_W <= COEF_W) begin : g_bad_div
      $error("dividend narrower than coefficient field");
   end
   if ((MAX_DS < 1) || (OUT_LIMIT < 2)) begin : g_bad_cfg
      $error("illegal decimation or output limit");
   end

   rsz_state_e       state_q;
   logic             dim_q;
   logic [SZ_W-1:0]  in_q  [2];
   logic [SZ_W-1:0]  out_q [2];
   logic [DS_W-1:0]  ds_q  [2];
   logic [COEF_W-1:0] coef_q [2];
   logic             warn_q;
   rsz_err_e         ecode_q;

   logic [SZ_W-1:0]  cur_in, cur_out;
   rsz_err_e         pre_err;
   logic [DS_W-1:0]  pre_ds;
   logic [RED_W-1:0] pre_red;
   logic [RED_W-1:0] red_m1;
   logic [DVD_W-1:0] div_dvd;
   logic [DVS_W-1:0] div_dvs;
   logic             div_go, div_fin;
   logic [DVD_W-1:0] div_q;
   logic             sat_hit;
   logic [COEF_W-1:0] coef_sat;
   logic [WORD_W-1:0] packed_w;

   assign cur_in  = in_q[dim_q];
   assign cur_out = out_q[dim_q];

   rsz_prescale #(
      .SZ_W(SZ_W), .IN_LIMIT(IN_LIMIT), .OUT_LIMIT(OUT_LIMIT),
      .MAX_DS(MAX_DS), .DS_W(DS_W), .RED_W(RED_W)
   ) u_pre (
      .in_sz(cur_in), .out_sz(cur_out),
      .err(pre_err), .ds(pre_ds), .reduced(pre_red)
   );

   assign red_m1  = pre_red - 1'b1;
   assign div_dvd = {red_m1, {FRAC_BITS{1'b0}}};
   assign div_dvs = cur_out[DVS_W-1:0] - 1'b1;
   assign div_go  = (state_q == ST_CHECK) && (pre_err == RSZ_OK);

   rsz_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go),
      .dividend(div_dvd), .divisor(div_dvs),
      .fin(div_fin), .quotient(div_q)
   );

   assign sat_hit  = div_q >= SAT_LIM;
   assign coef_sat = sat_hit ? {COEF_W{1'b1}} : div_q[COEF_W-1:0];

   for (genvar g = 0; g < 2; g++) begin : g_pack
      assign packed_w[(2-g)*HALF_W-1 -: HALF_W] = {ds_q[g], coef_q[g]};
   end

   assign busy = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         dim_q    <= 1'b0;
         warn_q   <= 1'b0;
         ecode_q  <= RSZ_OK;
         done     <= 1'b0;
         rsc_word <= '0;
         err      <= 1'b0;
         err_code <= '0;
         ovf_warn <= 1'b0;
         for (int i = 0; i < 2; i++) begin
            in_q[i]   <= '0;
            out_q[i]  <= '0;
            ds_q[i]   <= '0;
            coef_q[i] <= '0;
         end
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  in_q[0]  <= in_h;
                  out_q[0] <= out_h;
                  in_q[1]  <= in_w;
                  out_q[1] <= out_w;
                  dim_q    <= 1'b0;
                  warn_q   <= 1'b0;
                  ecode_q  <= RSZ_OK;
                  state_q  <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (pre_err != RSZ_OK) begin
                  ecode_q <= pre_err;
                  state_q <= ST_FINISH;
               end else begin
                  ds_q[dim_q] <= pre_ds;
                  state_q     <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (div_fin) begin
                  coef_q[dim_q] <= coef_sat;
                  warn_q        <= warn_q | sat_hit;
                  if (dim_q) begin
                     state_q <= ST_FINISH;
                  end else begin
                     dim_q   <= 1'b1;
                     state_q <= ST_CHECK;
                  end
               end
            end
            ST_FINISH: begin
               done     <= 1'b1;
               err      <= (ecode_q != RSZ_OK);
               err_code <= ecode_q;
               rsc_word <= (ecode_q != RSZ_OK) ? '0 : packed_w;
               ovf_warn <= (ecode_q == RSZ_OK) && warn_q;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rsz_coef_calc_chk.sv
module rsz_coef_calc_chk #(
   parameter int COEF_W = 14
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [31:0] rsc_word,
   input logic        err,
   input logic [2:0]  err_code,
   input logic        ovf_warn
);

   localparam logic [COEF_W-1:0] SAT_V = {COEF_W{1'b1}};

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rsc_word) || $past(!rst_n)); // R9

   AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done)); // R10

   AST_ERR_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rsc_word == 32'd0)); // R1

   AST_ERR_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err == (err_code != 3'd0))); // R3

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_code <= 3'd4)); // R3

   AST_SAT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf_warn) |-> ((rsc_word[29:16] == SAT_V) || (rsc_word[13:0] == SAT_V))); // R7

   AST_DS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> ((rsc_word[31:30] != 2'd3) && (rsc_word[15:14] != 2'd3))); // R5

endmodule

bind rsz_coef_calc rsz_coef_calc_chk #(.COEF_W(COEF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rsc_word(rsc_word), .err(err), .err_code(err_code), .ovf_warn(ovf_warn)
);

// File: tb/rsz_coef_calc_tb_top.sv
module rsz_coef_calc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
   logic        busy, done, err, ovf_warn;
   logic [31:0] rsc_word;
   logic [2:0]  err_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   rsz_coef_calc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
      .busy(busy), .done(done), .rsc_word(rsc_word),
      .err(err), .err_code(err_code), .ovf_warn(ovf_warn)
   );

   int ilist [18] = '{0, 1, 2, 3, 7, 8, 63, 64, 200, 511, 1024, 1025,
                      2047, 2048, 4095, 4096, 4097, 5000};
   int olist [14] = '{0, 1, 2, 3, 5, 8, 17, 64, 100, 255, 512, 1023, 1024, 1025};

   task automatic chk(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Per-dimension model: code 1 in big, 2 out big, 4 illegal size, 3 ratio.
   function automatic void model(input int vi, input int vo, output int code,
                                 output int ds, output int coef, output bit w);
      longint q;
      int s;
      code = 0; ds = 0; coef = 0; w = 0;
      if (vi > 4096) code = 1;
      else if (vo > 1024) code = 2;
      else if (vo < 2 || vi == 0) code = 4;
      else if (4 * vo < vi) code = 3;
      if (code != 0) return;
      s = vi;
      while ((s > 1024 || s >= 2 * vo) && ds < 2) begin
         s = s / 2;
         ds++;
      end
      q = (64'd8192 * longint'(s - 1)) / longint'(vo - 1);
      if (q >= 16384) begin
         coef = 16383;
         w = 1;
      end else coef = int'(q);
   endfunction

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         if (done) begin
            ok = 1;
            break;
         end
      end
   endtask

   task automatic run_op(input int iw, input int ih, input int ow, input int oh, input bit chk_hold);
      int cv, dv, kv, ch, dh, kh, ec;
      bit wv, wh, ok, ew;
      logic [31:0] ew_word;
      string tag;
      model(ih, oh, cv, dv, kv, wv);
      model(iw, ow, ch, dh, kh, wh);
      ec = (cv != 0) ? cv : ch;
      ew = (ec == 0) && (wv || wh);
      ew_word = (ec != 0) ? 32'd0 :
                {dv[1:0], kv[13:0], dh[1:0], kh[13:0]};
      case (ec)
         1: tag = "R1";
         2: tag = "R2";
         3: tag = "R4";
         4: tag = "R3";
         default: tag = "R6";
      endcase
      if (cv != 0 && ch != 0 && cv != ch) tag = "R12";
      @(negedge clk);
      in_w = 16'(iw); in_h = 16'(ih); out_w = 16'(ow); out_h = 16'(oh);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (chk_hold) chk("R9 busy after start", busy === 1'b1, longint'(busy), 1);
      wait_done(ok);
      chk("R9 done timeout", ok, 0, 1);
      if (!ok) return;
      chk({tag, " err_code"}, err_code == 3'(ec), longint'(err_code), longint'(ec));
      chk({tag, " err flag"}, err == (ec != 0), longint'(err), longint'(ec != 0));
      chk((ec == 0) ? "R8 R5 R6 word" : "R1 word zero", rsc_word == ew_word,
          longint'(rsc_word), longint'(ew_word));
      chk("R7 ovf_warn", ovf_warn == ew, longint'(ovf_warn), longint'(ew));
      if (chk_hold) begin
         @(negedge clk);
         chk("R9 done one cycle", done == 1'b0, longint'(done), 0);
         chk("R9 word held", rsc_word == ew_word, longint'(rsc_word), longint'(ew_word));
         chk("R9 idle", busy == 1'b0, longint'(busy), 0);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<190000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cv, dv, kv, ch, dh, kh;
      bit wv, wh, ok;
      logic [31:0] ew_word;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", busy == 0, longint'(busy), 0);
      chk("R11 done", done == 0, longint'(done), 0);
      chk("R11 word", rsc_word == 0, longint'(rsc_word), 0);
      chk("R11 err", err == 0 && err_code == 0 && ovf_warn == 0,
          longint'({err, err_code, ovf_warn}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed edges: R5 decimation codes, R7 saturation, R12 precedence
      run_op(1000, 3, 1000, 2, 1'b1);
      run_op(4096, 4096, 1024, 1024, 1'b1);
      run_op(8, 8, 2, 2, 1'b0);
      run_op(9, 100, 2, 50, 1'b0);
      run_op(100, 5000, 0, 100, 1'b0);
      run_op(5000, 100, 100, 0, 1'b0);

      // Vertical sweep, horizontal legal; then horizontal sweep
      foreach (ilist[i]) foreach (olist[j]) run_op(100, ilist[i], 50, olist[j], 1'b0);
      foreach (ilist[i]) foreach (olist[j]) run_op(ilist[i], 100, olist[j], 50, 1'b0);

      // Pseudo-random batch
      for (int n = 0; n < 250; n++)
         run_op(int'($urandom_range(0, 4400)), int'($urandom_range(0, 4400)),
                int'($urandom_range(0, 1100)), int'($urandom_range(0, 1100)), 1'b0);

      // R10: second start mid-job is ignored
      model(300, 100, cv, dv, kv, wv);
      model(700, 200, ch, dh, kh, wh);
      ew_word = {dv[1:0], kv[13:0], dh[1:0], kh[13:0]};
      @(negedge clk);
      in_w = 16'd700; in_h = 16'd300; out_w = 16'd200; out_h = 16'd100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      in_w = 16'd5000; in_h = 16'd2; out_w = 16'd0; out_h = 16'd1000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R10 done", ok, 0, 1);
      chk("R10 err_code", err_code == 0, longint'(err_code), 0);
      chk("R10 word", rsc_word == ew_word, longint'(rsc_word), longint'(ew_word));
      repeat (3) @(negedge clk);
      chk("R10 no second job", busy == 0 && done == 0, longint'({busy, done}), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule